// File: doc/BRIEF.md
# Fetch-Block Branch Target Buffer

This block sits in the instruction-fetch front end and predicts where fetch goes after the current fetch block. Each cycle the fetch unit may present a block address. One cycle later the block answers with a hit flag and a next-fetch address. On a hit, that address is the stored next-block target, so fetch can redirect before any byte of the block is decoded. On a miss, it is the following sequential 16-byte block. One entry describes one whole fetch block, not one instruction. Entries exist only for blocks known to end in a taken branch. This covers unconditional jumps as well as conditional branches that were taken.

Later pipeline stages report resolved branches on an update port. The port carries the block address, a taken flag and the target. Handling is decided by one of five update actions:
- `ACT_IDLE`: nothing happens.
- `ACT_REFRESH`: the entry is present with the same target, so only recency is updated.
- `ACT_RETARGET`: the entry is present with a new target and is rewritten in place.
- `ACT_ALLOC`: the entry is absent, so a way is claimed.
- `ACT_DROP`: a not-taken report matches an entry, which is invalidated.

A taken report that the buffer could not have predicted (`ACT_RETARGET` or `ACT_ALLOC`) raises a one-cycle late-redirect flag. That flag marks the bubble that decode-time redirection costs. Storage is set-associative, with tree pseudo-LRU replacement per set. A flush clears every entry in one cycle.

Top module: `fetch_btb`

## Requirements
- R1: After reset, every lookup misses, `late_redirect_o` is low and `pred_hit_o` is low.
- R2: A missing lookup returns, on the next cycle, the lookup address with its low log2(BLK_BYTES)=4 bits cleared, plus BLK_BYTES (16).
- R3: A hitting lookup returns the stored next-fetch address on the next cycle, for any byte offset inside the block. A cycle with no lookup gives `pred_hit_o` low on the following cycle.
- R4: A taken update for a block with no entry allocates one, so a lookup issued after the update hits with that target.
- R5: A not-taken update never allocates, and it invalidates a matching entry; other entries in the set stay.
- R6: A taken update for a present block with a different target overwrites that entry in place. Later lookups return the new target, and no set ever holds two matching ways.
- R7: `late_redirect_o` is high for exactly the cycle after a taken update whose block was absent or held a different target. It is low after any other update.
- R8: Allocation picks the lowest-numbered invalid way if one exists. Otherwise it picks the tree pseudo-LRU victim. Lookup hits and updates refresh recency.
- R9: The set index is address bits [OFF+IDXW-1:OFF] and the partial tag is the next TAGW bits. Two blocks 2^(OFF+IDXW+TAGW) bytes apart alias, so one hits with the other's target.
- R10: When a lookup and an update occur in the same cycle, the update is committed at that edge. The lookup result reflects the state before the update.
- R11: `flush_i` clears all entries in one cycle, and a lookup in the following cycle misses. A flush overrides a simultaneous update.
- R12: Capacity is SETS x WAYS entries (default 1024 x 4 = 4096). A set holds WAYS taken blocks before eviction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Invalidate all entries |
| fetch_valid_i | input | 1 | Lookup request |
| fetch_addr_i | input | AW | Fetch address to look up |
| pred_hit_o | output | 1 | Lookup of the previous cycle hit |
| pred_next_o | output | AW | Predicted next-fetch address |
| upd_valid_i | input | 1 | Resolved-branch report |
| upd_addr_i | input | AW | Block address of the resolved branch |
| upd_taken_i | input | 1 | Branch was taken |
| upd_target_i | input | AW | Next-fetch address after the taken branch |
| late_redirect_o | output | 1 | Taken branch was not predicted by the buffer |

## Verification
A lookup's hit flag and next address are registered, so they are due one rising edge after the request. `late_redirect_o` likewise follows its update by one edge. The bench drives every request on a falling edge and samples the answer on the next falling edge, which sits between that register edge and the next one. An update only becomes visible to lookups issued in a later cycle. The bench therefore issues the confirming lookup after the update cycle has closed, and uses a same-cycle pair to show the older view. Eviction order is predicted from the known sequence of fills and touches in a two-way, four-set configuration. Every one of the 64 blocks in the small address space is swept for the sequential fallback.

// File: rtl/fbtb_pkg.sv
package fbtb_pkg;
    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_REFRESH,
        ACT_RETARGET,
        ACT_ALLOC,
        ACT_DROP
    } upd_act_e;
endpackage

// File: rtl/fbtb_ways.sv
module fbtb_ways #(
    parameter int AW   = 32,
    parameter int SETS = 1024,
    parameter int WAYS = 4,
    parameter int TAGW = 12,
    localparam int IDXW = $clog2(SETS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic [IDXW-1:0]          rd_idx,
    input  logic [TAGW-1:0]          rd_tag,
    output logic [WAYS-1:0]          rd_match,
    output logic [WAYS-1:0][AW-1:0]  rd_tgt,
    input  logic [IDXW-1:0]          up_idx,
    input  logic [TAGW-1:0]          up_tag,
    output logic [WAYS-1:0]          up_match,
    output logic [WAYS-1:0]          up_vld,
    output logic [WAYS-1:0][AW-1:0]  up_tgt,
    input  logic                     wr_en,
    input  logic                     clr_en,
    input  logic [WAYS-1:0]          wr_oh,
    input  logic [AW-1:0]            wr_tgt
);
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [SETS-1:0] valid_q;
        logic [TAGW-1:0] tag_q [SETS];
        logic [AW-1:0]   tgt_q [SETS];

        always_ff @(posedge clk) begin
            if (!rst_n || flush) begin
                valid_q <= '0;
            end else if (wr_en && wr_oh[w]) begin
                valid_q[up_idx] <= 1'b1;
            end else if (clr_en && wr_oh[w]) begin
                valid_q[up_idx] <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (wr_en && wr_oh[w]) begin
                tag_q[up_idx] <= up_tag;
                tgt_q[up_idx] <= wr_tgt;
            end
        end

        assign rd_match[w] = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
        assign rd_tgt[w]   = tgt_q[rd_idx];
        assign up_match[w] = valid_q[up_idx] && (tag_q[up_idx] == up_tag);
        assign up_vld[w]   = valid_q[up_idx];
        assign up_tgt[w]   = tgt_q[up_idx];
    end

    // No block may ever own two ways of one set
    assert_unique_lookup_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_match));
    assert_unique_update_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(up_match));
endmodule

// File: rtl/fbtb_plru.sv
module fbtb_plru #(
    parameter int SETS = 1024,
    parameter int WAYS = 4,
    localparam int IDXW = $clog2(SETS),
    localparam int LW   = $clog2(WAYS),
    localparam int NB   = WAYS - 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lk_touch,
    input  logic [IDXW-1:0] lk_idx,
    input  logic [LW-1:0]   lk_way,
    input  logic            up_touch,
    input  logic [IDXW-1:0] up_idx,
    input  logic [LW-1:0]   up_way,
    output logic [LW-1:0]   vic_way
);
    logic [NB-1:0] tree_q [SETS];
    logic [NB-1:0] up_next, lk_base, lk_next;

    // Each node bit points toward the side holding the victim
    function automatic logic [NB-1:0] touch_f(input logic [NB-1:0] b, input logic [LW-1:0] w);
        logic [NB-1:0] r;
        int n;
        r = b;
        n = 0;
        for (int l = LW - 1; l >= 0; l--) begin
            r[n] = ~w[l];
            n = 2 * n + 1 + (w[l] ? 1 : 0);
        end
        return r;
    endfunction

    function automatic logic [LW-1:0] victim_f(input logic [NB-1:0] b);
        logic [LW-1:0] v;
        int n;
        v = '0;
        n = 0;
        for (int l = LW - 1; l >= 0; l--) begin
            v[l] = b[n];
            n = 2 * n + 1 + (b[n] ? 1 : 0);
        end
        return v;
    endfunction

    always_comb begin
        up_next = touch_f(tree_q[up_idx], up_way);
        lk_base = (up_touch && (up_idx == lk_idx)) ? up_next : tree_q[lk_idx];
        lk_next = touch_f(lk_base, lk_way);
        vic_way = victim_f(tree_q[up_idx]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
        end else begin
            if (up_touch) tree_q[up_idx] <= up_next;
            if (lk_touch) tree_q[lk_idx] <= lk_next;
        end
    end
endmodule

// File: rtl/fetch_btb.sv
module fetch_btb #(
    parameter int AW        = 32,
    parameter int BLK_BYTES = 16,
    parameter int SETS      = 1024,
    parameter int WAYS      = 4,
    parameter int TAGW      = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush_i,
    input  logic          fetch_valid_i,
    input  logic [AW-1:0] fetch_addr_i,
    output logic          pred_hit_o,
    output logic [AW-1:0] pred_next_o,
    input  logic          upd_valid_i,
    input  logic [AW-1:0] upd_addr_i,
    input  logic          upd_taken_i,
    input  logic [AW-1:0] upd_target_i,
    output logic          late_redirect_o
);
    import fbtb_pkg::*;

    localparam int OFF  = $clog2(BLK_BYTES);
    localparam int IDXW = $clog2(SETS);
    localparam int LW   = $clog2(WAYS);
    localparam int BW   = AW - OFF;

    logic [IDXW-1:0]         lk_idx, up_idx;
    logic [TAGW-1:0]         lk_tag, up_tag;
    logic [WAYS-1:0]         rd_match, up_match, up_vld;
    logic [WAYS-1:0][AW-1:0] rd_tgt, up_tgt;
    logic [LW-1:0]           lk_way, hit_way, free_way, vic_way, touch_way;
    logic [AW-1:0]           lk_tgt, hit_tgt, seq_next;
    logic [BW-1:0]           blk_next;
    logic [WAYS-1:0]         free_oh, alloc_oh, wr_oh;
    logic                    lk_hit, free_found, wr_en, clr_en, up_touch, late_d;
    logic                    hit_q, late_q;
    logic [AW-1:0]           next_q;
    upd_act_e                act;

    assign lk_idx = fetch_addr_i[OFF +: IDXW];
    assign lk_tag = fetch_addr_i[OFF + IDXW +: TAGW];
    assign up_idx = upd_addr_i[OFF +: IDXW];
    assign up_tag = upd_addr_i[OFF + IDXW +: TAGW];

    fbtb_ways #(.AW(AW), .SETS(SETS), .WAYS(WAYS), .TAGW(TAGW)) u_ways (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush_i),
        .rd_idx  (lk_idx),
        .rd_tag  (lk_tag),
        .rd_match(rd_match),
        .rd_tgt  (rd_tgt),
        .up_idx  (up_idx),
        .up_tag  (up_tag),
        .up_match(up_match),
        .up_vld  (up_vld),
        .up_tgt  (up_tgt),
        .wr_en   (wr_en),
        .clr_en  (clr_en),
        .wr_oh   (wr_oh),
        .wr_tgt  (upd_target_i)
    );

    fbtb_plru #(.SETS(SETS), .WAYS(WAYS)) u_plru (
        .clk     (clk),
        .rst_n   (rst_n),
        .lk_touch(lk_hit && !flush_i),
        .lk_idx  (lk_idx),
        .lk_way  (lk_way),
        .up_touch(up_touch),
        .up_idx  (up_idx),
        .up_way  (touch_way),
        .vic_way (vic_way)
    );

    // Lookup side: way select and sequential fallback
    always_comb begin
        lk_way = '0;
        lk_tgt = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (rd_match[w]) begin
                lk_way = LW'(w);
                lk_tgt = rd_tgt[w];
            end
        end
        lk_hit   = fetch_valid_i && (|rd_match);
        blk_next = fetch_addr_i[AW-1:OFF] + BW'(1);
        seq_next = {blk_next, {OFF{1'b0}}};
    end

    // Update side: matching way, first free way
    always_comb begin
        hit_way    = '0;
        hit_tgt    = '0;
        free_way   = '0;
        free_oh    = '0;
        free_found = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (up_match[w]) begin
                hit_way = LW'(w);
                hit_tgt = up_tgt[w];
            end
            if (!free_found && !up_vld[w]) begin
                free_found  = 1'b1;
                free_way    = LW'(w);
                free_oh[w]  = 1'b1;
            end
        end
        alloc_oh = free_found ? free_oh : (WAYS'(1) << vic_way);
    end

    // Action decode
    always_comb begin
        act = ACT_IDLE;
        if (upd_valid_i && !flush_i) begin
            if (upd_taken_i) begin
                if (|up_match) act = (hit_tgt == upd_target_i) ? ACT_REFRESH : ACT_RETARGET;
                else           act = ACT_ALLOC;
            end else if (|up_match) begin
                act = ACT_DROP;
            end
        end
    end

    // Per-action outputs toward storage and replacement
    always_comb begin
        wr_en     = 1'b0;
        clr_en    = 1'b0;
        wr_oh     = '0;
        up_touch  = 1'b0;
        touch_way = hit_way;
        late_d    = 1'b0;
        unique case (act)
            ACT_IDLE: ;
            ACT_REFRESH: begin
                up_touch = 1'b1;
            end
            ACT_RETARGET: begin
                wr_en    = 1'b1;
                wr_oh    = up_match;
                up_touch = 1'b1;
                late_d   = 1'b1;
            end
            ACT_ALLOC: begin
                wr_en     = 1'b1;
                wr_oh     = alloc_oh;
                up_touch  = 1'b1;
                touch_way = free_found ? free_way : vic_way;
                late_d    = 1'b1;
            end
            ACT_DROP: begin
                clr_en = 1'b1;
                wr_oh  = up_match;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q  <= 1'b0;
            next_q <= '0;
            late_q <= 1'b0;
        end else begin
            hit_q  <= lk_hit;
            next_q <= lk_hit ? lk_tgt : seq_next;
            late_q <= late_d;
        end
    end

    assign pred_hit_o      = hit_q;
    assign pred_next_o     = next_q;
    assign late_redirect_o = late_q;

    assert_miss_fallback_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid_i |=> (pred_hit_o ||
            ((pred_next_o[AW-1:OFF] == $past(fetch_addr_i[AW-1:OFF]) + BW'(1)) &&
             (pred_next_o[OFF-1:0] == '0))));
    assert_idle_nohit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid_i |=> !pred_hit_o);
    assert_nottaken_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid_i && !upd_taken_i) |=> !late_redirect_o);
    assert_flush_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i ##1 fetch_valid_i |=> !pred_hit_o);
    assert_fill_free_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_ALLOC && !(&up_vld)) |-> ((alloc_oh & up_vld) == '0));
endmodule

// File: tb/fetch_btb_test.sv
module fetch_btb_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush_i = 1'b0;
    logic        fetch_valid_i = 1'b0;
    logic [15:0] fetch_addr_i = '0;
    logic        pred_hit_o;
    logic [15:0] pred_next_o;
    logic        upd_valid_i = 1'b0;
    logic [15:0] upd_addr_i = '0;
    logic        upd_taken_i = 1'b0;
    logic [15:0] upd_target_i = '0;
    logic        late_redirect_o;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Small configuration: index = addr[5:4], tag = addr[9:6], alias stride 0x400
    fetch_btb #(.AW(16), .BLK_BYTES(16), .SETS(4), .WAYS(2), .TAGW(4)) uut (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
        .fetch_valid_i(fetch_valid_i), .fetch_addr_i(fetch_addr_i),
        .pred_hit_o(pred_hit_o), .pred_next_o(pred_next_o),
        .upd_valid_i(upd_valid_i), .upd_addr_i(upd_addr_i),
        .upd_taken_i(upd_taken_i), .upd_target_i(upd_target_i),
        .late_redirect_o(late_redirect_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] seq_of(input logic [15:0] a);
        return 16'(((a >> 4) + 16'd1) << 4);
    endfunction

    task automatic look(input logic [15:0] a, input bit eh, input logic [15:0] et, input string req);
        @(negedge clk);
        fetch_valid_i = 1'b1;
        fetch_addr_i  = a;
        @(negedge clk);
        fetch_valid_i = 1'b0;
        check(req, {31'd0, pred_hit_o}, {31'd0, eh});
        check(req, {16'd0, pred_next_o}, {16'd0, eh ? et : seq_of(a)});
    endtask

    task automatic upd(input logic [15:0] a, input bit tk, input logic [15:0] tg, input bit elate, input string req);
        @(negedge clk);
        upd_valid_i  = 1'b1;
        upd_addr_i   = a;
        upd_taken_i  = tk;
        upd_target_i = tg;
        @(negedge clk);
        upd_valid_i = 1'b0;
        check(req, {31'd0, late_redirect_o}, {31'd0, elate});
    endtask

    task automatic do_flush;
        @(negedge clk);
        flush_i = 1'b1;
        @(negedge clk);
        flush_i = 1'b0;
    endtask

    function automatic logic [15:0] blk(input int tag, input int idx);
        return 16'(tag * 64 + idx * 16);
    endfunction

    function automatic logic [15:0] tgt(input int tag, input int idx);
        return 16'(16'h8000 + tag * 16'h100 + idx * 16'h10);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset hit", {31'd0, pred_hit_o}, 32'd0);
        check("R1 reset late", {31'd0, late_redirect_o}, 32'd0);

        // R1 R2: all 64 blocks miss with the sequential fallback
        for (int i = 0; i < 64; i++)
            look(16'(i * 16 + (i % 16)), 1'b0, 16'h0, "R2 fallback sweep");

        // R4 R7: allocate on a taken report
        upd(16'h0100, 1'b1, 16'h2000, 1'b1, "R7 late on alloc");
        look(16'h0100, 1'b1, 16'h2000, "R4 hit after alloc");
        look(16'h010C, 1'b1, 16'h2000, "R3 hit any offset");

        // R5: not-taken report does not allocate
        upd(16'h0080, 1'b0, 16'h3000, 1'b0, "R7 quiet on not-taken");
        look(16'h0080, 1'b0, 16'h0, "R5 no alloc when not taken");

        // R7: same target gives no late redirect
        upd(16'h0100, 1'b1, 16'h2000, 1'b0, "R7 quiet when predicted");

        // R6: retarget in place
        upd(16'h0100, 1'b1, 16'h2400, 1'b1, "R7 late on retarget");
        look(16'h0100, 1'b1, 16'h2400, "R6 new target");

        // R10: same-cycle lookup and update
        @(negedge clk);
        fetch_valid_i = 1'b1; fetch_addr_i = 16'h0110;
        upd_valid_i = 1'b1; upd_addr_i = 16'h0110; upd_taken_i = 1'b1; upd_target_i = 16'h2C00;
        @(negedge clk);
        fetch_valid_i = 1'b0; upd_valid_i = 1'b0;
        check("R10 lookup sees old state", {31'd0, pred_hit_o}, 32'd0);
        check("R10 fallback", {16'd0, pred_next_o}, 32'h0120);
        check("R10 late", {31'd0, late_redirect_o}, 32'd1);
        look(16'h0110, 1'b1, 16'h2C00, "R10 update committed");

        // R3: idle cycle gives no hit
        @(negedge clk);
        check("R3 idle no hit", {31'd0, pred_hit_o}, 32'd0);

        // R9: aliasing through the partial tag
        look(16'h0500, 1'b1, 16'h2400, "R9 alias hit");
        look(16'h0140, 1'b0, 16'h0, "R9 other tag misses");

        // R11: flush
        do_flush;
        look(16'h0100, 1'b0, 16'h0, "R11 flushed");
        look(16'h0110, 1'b0, 16'h0, "R11 flushed");

        // R8: replacement order in set 0
        upd(16'h0000, 1'b1, 16'h1000, 1'b1, "R8 fill A");
        upd(16'h0040, 1'b1, 16'h1100, 1'b1, "R8 fill B");
        look(16'h0000, 1'b1, 16'h1000, "R8 touch A");
        upd(16'h0080, 1'b1, 16'h1200, 1'b1, "R8 alloc C");
        look(16'h0000, 1'b1, 16'h1000, "R8 A kept");
        look(16'h0040, 1'b0, 16'h0, "R8 B evicted");
        look(16'h0080, 1'b1, 16'h1200, "R8 C present");
        upd(16'h00C0, 1'b1, 16'h1300, 1'b1, "R8 alloc D");
        look(16'h0000, 1'b0, 16'h0, "R8 A evicted");
        look(16'h0080, 1'b1, 16'h1200, "R8 C kept");
        look(16'h00C0, 1'b1, 16'h1300, "R8 D present");

        // R12: fill capacity, then one more per set
        do_flush;
        for (int s = 0; s < 4; s++)
            for (int t = 0; t < 2; t++)
                upd(blk(t, s), 1'b1, tgt(t, s), 1'b1, "R12 fill");
        for (int s = 0; s < 4; s++)
            for (int t = 0; t < 2; t++)
                look(blk(t, s), 1'b1, tgt(t, s), "R12 full hit");
        for (int s = 0; s < 4; s++)
            upd(blk(2, s), 1'b1, tgt(2, s), 1'b1, "R12 overflow alloc");
        for (int s = 0; s < 4; s++) begin
            look(blk(0, s), 1'b0, 16'h0, "R12 LRU evicted");
            look(blk(1, s), 1'b1, tgt(1, s), "R12 kept");
            look(blk(2, s), 1'b1, tgt(2, s), "R12 new");
        end

        // R5: invalidate one entry, neighbour stays
        upd(blk(1, 0), 1'b0, 16'h0, 1'b0, "R5 drop quiet");
        look(blk(1, 0), 1'b0, 16'h0, "R5 invalidated");
        look(blk(2, 0), 1'b1, tgt(2, 0), "R5 neighbour kept");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule